// File: doc/BRIEF.md
# Operating-System Tick Timer with Interval and Free-Running Compare Modes

This block is a memory-mapped timer that software uses as its system tick source. It has a compare register, a readable counter, and write-one trigger registers that start and stop counting. A read-only status bit shows whether the timer is counting. A control register selects the counting mode and decides whether an interrupt is raised at the moment counting begins. A single-cycle register bus carries address, write strobe and word data. Reads are combinational. One interrupt request output pulses for each timer event.

The timer has two modes. In free-running compare mode, a start clears the counter, and the counter then counts up without limit. An interrupt fires each time the counter equals the absolute value held in the compare register. In interval mode, the counter loads the compare value on start and counts down. On reaching zero it reloads and interrupts, so it produces a periodic tick every compare+1 clocks. Software may rewrite the compare register at any time. The control register is frozen while counting.

The run sequencing is a two-state machine with the states ST_IDLE and ST_RUN. The transition T_START (ST_IDLE to ST_RUN) is taken on a start trigger. The transition T_STOP (ST_RUN to ST_IDLE) is taken on a stop trigger. A start trigger in ST_RUN and a stop trigger in ST_IDLE leave the state unchanged.

Top module: `os_tick_timer`

## Requirements
- R1: After reset the timer is stopped: the status bit reads 0, `irq` is low, and the compare and control registers read 0.
- R2: Byte offsets: compare 0x00 (read/write), counter 0x04 (read-only), status 0x10 (bit 0 = counting), start trigger 0x14, stop trigger 0x18, control 0x20. In the control register, bit 0 enables the interrupt at start and bit 1 selects the mode (1 = free-running, 0 = interval). Trigger offsets and unmapped offsets read 0.
- R3: A write of 1 to bit 0 of the start trigger while stopped takes T_START, and the status bit reads 1 from the next cycle. A start write with bit 0 clear has no effect.
- R4: A write of 1 to bit 0 of the stop trigger while counting takes T_STOP. The status bit reads 0 one clock later, and the counter then holds its value.
- R5: In free-running mode a start sets the counter to 0, and the counter then increments by one every clock, modulo 2^32.
- R6: In free-running mode, `irq` pulses in the clock after the counter equals the compare value, and counting continues past the match. The first match interrupt therefore appears compare+1 clocks after the start edge.
- R7: In interval mode the counter loads the compare value on start and decrements each clock. When it reaches 0 it reloads the compare value and `irq` pulses in the following clock, giving a period of compare+1 clocks.
- R8: When control bit 0 is 1, `irq` pulses in the clock right after the start edge. When it is 0, no interrupt is raised at start.
- R9: The compare register may be rewritten while counting, and the next match uses the new value.
- R10: Writes to the control register are ignored while counting. Writes to the counter offset are always ignored.
- R11: `irq` is high for only one clock per event, and no event is raised while the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset within the 0x30 register window |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, one-clock pulse per event |

## Verification
The bench measures the distance from the start edge to the first interrupt for random compare values, including compare 0. An off-by-one in the match or reload path shifts this distance by a clock. It restarts free-running mode after a stop to catch a counter that is not cleared on start. It rewrites compare mid-run to expose a design that latches the target only at start. It also writes control and counter while counting, and watches `irq` while stopped, so that missing write guards and stray events are caught at the ports.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam int OFF_CMP   = 'h00;
    localparam int OFF_CNT   = 'h04;
    localparam int OFF_STAT  = 'h10;
    localparam int OFF_START = 'h14;
    localparam int OFF_STOP  = 'h18;
    localparam int OFF_CTL   = 'h20;

    localparam int CTL_W       = 2;
    localparam int CTL_IRQ_BIT = 0;
    localparam int CTL_MODE_BIT = 1;
endpackage

// File: rtl/ostm_regs.sv
module ostm_regs
    import ostm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              running,
    output logic [DATA_W-1:0] cmp_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              start_req,
    output logic              stop_req
);
    logic hit_cmp, hit_ctl;

    always_comb begin
        hit_cmp   = wr && (addr == ADDR_W'(OFF_CMP));
        hit_ctl   = wr && (addr == ADDR_W'(OFF_CTL));
        start_req = wr && (addr == ADDR_W'(OFF_START)) && wdata[0];
        stop_req  = wr && (addr == ADDR_W'(OFF_STOP)) && wdata[0];
    end

    // compare may change at any time; control only while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            ctl_q <= '0;
        end else begin
            if (hit_cmp) begin
                cmp_q <= wdata;
            end
            if (hit_ctl && !running) begin
                ctl_q <= wdata[CTL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ostm_fsm.sv
module ostm_fsm
    import ostm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    output logic running,
    output logic start_evt
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        running   = 1'b0;
        start_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d   = ST_RUN;   // T_START
                    start_evt = 1'b1;
                end
            end
            ST_RUN: begin
                running = 1'b1;
                if (stop_req) begin
                    state_d = ST_IDLE;    // T_STOP
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/ostm_counter.sv
module ostm_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              running,
    input  logic              free_mode,
    input  logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] cnt_q,
    output logic              match_evt
);
    logic at_zero;

    always_comb begin
        at_zero   = (cnt_q == '0);
        match_evt = running && (free_mode ? (cnt_q == cmp) : at_zero);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_evt) begin
            cnt_q <= free_mode ? '0 : cmp;
        end else if (running) begin
            if (free_mode) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (at_zero) begin
                cnt_q <= cmp;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
    import ostm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] cmp_w, cnt_w;
    logic [CTL_W-1:0]  ctl_w;
    logic start_req_w, stop_req_w, run_w, start_evt_w, match_w, free_w;
    logic irq_q;

    assign free_w = ctl_w[CTL_MODE_BIT];

    ostm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .running(run_w), .cmp_q(cmp_w), .ctl_q(ctl_w),
        .start_req(start_req_w), .stop_req(stop_req_w)
    );

    ostm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req_w),
        .stop_req(stop_req_w), .running(run_w), .start_evt(start_evt_w)
    );

    ostm_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt_w), .running(run_w),
        .free_mode(free_w), .cmp(cmp_w), .cnt_q(cnt_w), .match_evt(match_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= match_w || (start_evt_w && ctl_w[CTL_IRQ_BIT]);
        end
    end

    assign irq = irq_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CMP)) begin
            bus_rdata = cmp_w;
        end else if (bus_addr == ADDR_W'(OFF_CNT)) begin
            bus_rdata = cnt_w;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            bus_rdata = DATA_W'(run_w);
        end else if (bus_addr == ADDR_W'(OFF_CTL)) begin
            bus_rdata = DATA_W'(ctl_w);
        end
    end
endmodule

// File: rtl/ostm_sva.sv
module ostm_sva #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              free_mode,
    input logic [DATA_W-1:0] cnt,
    input logic [1:0]        ctl,
    input logic              stop_req,
    input logic              irq
);
    AST_STOP_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        run && stop_req |=> !run); // R4
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !$past(run) |-> $stable(cnt)); // R4
    AST_FREE_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) && free_mode |-> cnt == '0); // R5
    AST_FREE_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && free_mode |-> cnt == $past(cnt) + 1'b1); // R5
    AST_INTERVAL_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !free_mode && $past(cnt) != '0 |-> cnt == $past(cnt) - 1'b1); // R7
    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> $stable(ctl)); // R10
    AST_NO_IRQ_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run) || $rose(run)); // R11
endmodule

bind os_tick_timer ostm_sva #(.DATA_W(DATA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .run(run_w), .free_mode(free_w),
    .cnt(cnt_w), .ctl(ctl_w), .stop_req(stop_req_w), .irq(irq)
);

// File: tb/os_tick_timer_test.sv
module os_tick_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10,
                           A_START = 6'h14, A_STOP = 6'h18, A_CTL = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    os_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_first_irq(int c);
        return c + 1;
    endfunction

    function automatic logic [31:0] exp_cnt_at_irq(bit free, int c);
        return free ? 32'(c + 1) : 32'(c);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; consumes one rising edge, returns at the next negedge
    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(A_STAT, v); check("R1 status", v, 0);
        check("R1 irq", 32'(irq), 0);
        rd(A_CMP, v);  check("R1 compare", v, 0);
        rd(A_CTL, v);  check("R1 control", v, 0);

        wr(A_CTL, 32'h2); rd(A_CTL, v); check("R2 control readback", v, 2);
        wr(A_CMP, 32'd5); rd(A_CMP, v); check("R2 compare readback", v, 5);
        rd(6'h08, v); check("R2 unmapped reads 0", v, 0);
        rd(A_START, v); check("R2 trigger reads 0", v, 0);

        wr(A_START, 32'h0); rd(A_STAT, v); check("R3 start bit0=0 ignored", v, 0);
        wr(A_START, 32'h1); rd(A_STAT, v); check("R3 status after start", v, 1);
        rd(A_CNT, v); check("R5 counter cleared on start", v, 0);
        check("R8 no start irq when disabled", 32'(irq), 0);

        wait_irq(n); check("R6 first match delay", 32'(n), 32'(exp_first_irq(5)));
        @(negedge clk);
        check("R11 single-clock pulse", 32'(irq), 0);
        rd(A_CNT, v); check("R6 counting continues", v, 7);

        wr(A_CTL, 32'h0); rd(A_CTL, v); check("R10 control frozen", v, 2);
        rd(A_CNT, v); wr(A_CNT, 32'h0); rd(A_CNT, v2);
        check("R10 counter write ignored", v2, v + 1);

        wr(A_STOP, 32'h1); rd(A_STAT, v); check("R4 status cleared", v, 0);
        rd(A_CNT, v);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq) n++;
        end
        rd(A_CNT, v2); check("R4 counter holds", v2, v);
        check("R11 no irq while stopped", 32'(n), 0);

        wr(A_START, 32'h1); rd(A_CNT, v); check("R5 restart clears counter", v, 0);
        wr(A_CMP, 32'd12);
        wait_irq(n); check("R9 new compare used", 32'(n), 32'd12);
        wr(A_STOP, 32'h1);

        wr(A_CTL, 32'h1); wr(A_CMP, 32'd3);
        wr(A_START, 32'h1);
        check("R8 start irq", 32'(irq), 1);
        rd(A_CNT, v); check("R7 loads compare", v, 3);
        @(negedge clk);
        wait_irq(n); check("R7 first period", 32'(n + 1), 32'd4);
        @(negedge clk);
        wait_irq(n); check("R7 reload period", 32'(n + 1), 32'd4);
        wr(A_STOP, 32'h1);

        for (int it = 0; it < 12; it++) begin
            bit free = 1'($urandom_range(0, 1));
            bit ie = 1'($urandom_range(0, 1));
            int c = int'($urandom_range(0, 30));
            wr(A_CMP, 32'(c));
            wr(A_CTL, {30'b0, free, ie});
            wr(A_START, 32'h1);
            check("R8 random start irq", 32'(irq), 32'(ie));
            n = 0;
            if (ie) begin
                @(negedge clk);
                n = 1;
            end
            while (!irq && n < 300) begin
                @(negedge clk);
                n++;
            end
            check(free ? "R6 random match delay" : "R7 random period",
                  32'(n), 32'(exp_first_irq(c)));
            rd(A_CNT, v);
            check(free ? "R5 random counter" : "R7 random counter",
                  v, exp_cnt_at_irq(free, c));
            wr(A_STOP, 32'h1);
            rd(A_STAT, v); check("R4 random stop", v, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule